// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block turns a byte stream into a low-speed USB line waveform on D+ and D-, with every bit held for a fixed number of clocks (eight by default). A packet starts when `tx_start` arrives with a byte count. The count includes the sync byte, and the sync byte is the first byte of the stream. Bytes then come in over a ready/valid handshake. A reply handshake is started with `hs_req` instead. In that case the block makes up both the sync byte and the ACK or NAK PID itself. For every packet the block does the following in order:
1. It presents the idle level with the pull-up on.
2. It enables the drivers.
3. It sends the bits with NRZI coding and bit stuffing.
4. It ends with an end-of-packet of SE0 followed by J.
5. It releases the drivers.
6. One clock later it turns the pull-up off.

A device address written into a pending register only becomes the active address when a data packet ends. A handshake never commits it.

The controller is one state machine with these states and transitions:
- IDLE goes to LOAD on an accepted request.
- LOAD goes to ARM once the first byte is held.
- ARM goes to BITS after one clock.
- BITS goes to SE0 when no bit, stuff slot or byte remains.
- SE0 goes to EOPJ after two bit slots.
- EOPJ goes to REL after one bit slot.
- REL goes to IDLE after one clock.

Top module: `usb_ls_tx`

## Requirements
- R1: While in reset, `out_en`, `pullup_en`, `dp_out`, `dm_out`, `busy`, `tx_ready` and `dev_addr` are all 0.
- R2: For exactly one clock before the drivers turn on, the outputs show J (`dp_out`=0, `dm_out`=1) with `pullup_en`=1 and `out_en`=0.
- R3: Each line slot lasts CLK_PER_BIT (8) clocks, and the line changes only at slot boundaries. J is `dp_out`=0 with `dm_out`=1, and K is `dp_out`=1 with `dm_out`=0.
- R4: A data packet carries exactly `tx_len` bytes, taken in order over `tx_data` with `tx_valid`/`tx_ready`. The first of these bytes is the sync byte. Each byte goes out least significant bit first.
- R5: The line uses NRZI coding: a 0 bit toggles the line level and a 1 bit holds it.
- R6: After six 1 bits in a row, one extra toggling slot is inserted. This also happens after the final data bit, before end-of-packet. Any toggle restarts the run count.
- R7: End-of-packet is SE0 (both lines 0) for 16 clocks, then J for 8 clocks. After that, `out_en` drops while `pullup_en` stays high for one more clock, and then `pullup_en` drops too.
- R8: `hs_req` sends two bytes: 0x80 then 0xD2 (ACK) when `hs_nak`=0, or 0x80 then 0x5A (NAK) when `hs_nak`=1. If `hs_req` and `tx_start` arrive in the same cycle, `hs_req` wins and `tx_start` is dropped.
- R9: The drivers are enabled no later than 60 clocks after `hs_req` is taken.
- R10: `addr_wr` loads `addr_in` into a pending register. `dev_addr` takes the pending value in the first SE0 cycle of a data packet, and it never changes on a handshake.
- R11: `tx_start` and `hs_req` are ignored while `busy` is high. A `tx_start` with `tx_len`=0 is ignored.
- R12: `dp_out` and `dm_out` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_PER_BIT clocks per line bit |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start a data packet |
| tx_len | input | LEN_W | Byte count including the sync byte |
| tx_data | input | 8 | Stream byte |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block takes `tx_data` this cycle if valid |
| hs_req | input | 1 | Send a handshake packet |
| hs_nak | input | 1 | Handshake select: 0 ACK, 1 NAK |
| addr_wr | input | 1 | Load the pending address |
| addr_in | input | ADDR_W | New device address |
| dev_addr | output | ADDR_W | Active device address |
| dp_out | output | 1 | D+ output level |
| dm_out | output | 1 | D- output level |
| out_en | output | 1 | Drive both lines |
| pullup_en | output | 1 | Pull-up enable |
| busy | output | 1 | Packet in progress |

## Verification
The bench decodes the line waveform mid-slot and strips stuff bits. It rebuilds each byte and compares it with a scoreboard queue, and it also times every slot and the end-of-packet phases.

The corner cases it targets are these:
- A run of six ones that ends the packet. A design that checks stuffing only between bits would go to SE0 with a stuff slot still owed.
- Long runs of 0xFF. A counter that does not restart on toggles, or that restarts on the stuff slot at the wrong point, would insert slots in the wrong place.
- A handshake sent while an address is pending. A design that commits the address on every end-of-packet would change `dev_addr` at the wrong time.
- Requests that arrive while busy, at the same time as each other, or with a zero length. A controller that is not gated on IDLE would start a second packet or truncate the current one.

// File: rtl/usb_ls_tx_pkg.sv
`timescale 1ns/1ps
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARM,
        ST_BITS,
        ST_SE0,
        ST_EOPJ,
        ST_REL
    } tx_state_e;

    localparam logic [7:0] SYNC_PATTERN = 8'h80;
    localparam logic [7:0] PID_ACK      = 8'hD2;
    localparam logic [7:0] PID_NAK      = 8'h5A;

endpackage

// File: rtl/usb_ls_slot_timer.sv
`timescale 1ns/1ps
module usb_ls_slot_timer #(
    parameter int CLK_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end
);
    localparam int PH_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

    logic [PH_W-1:0] phase;

    assign slot_end = run && (phase == PH_W'(CLK_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || slot_end) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/usb_ls_nrzi.sv
`timescale 1ns/1ps
module usb_ls_nrzi #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    input  logic bit_in,
    input  logic stuff_slot,
    output logic line_j,
    output logic stuff_due
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [RUN_W-1:0] run_left;
    logic             level_j;

    assign line_j    = level_j;
    assign stuff_due = (run_left == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            level_j  <= 1'b1;
            run_left <= RUN_W'(STUFF_RUN);
        end else if (step) begin
            if (stuff_slot || !bit_in) begin
                level_j  <= ~level_j;
                run_left <= RUN_W'(STUFF_RUN);
            end else begin
                run_left <= run_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_ls_tx.sv
`timescale 1ns/1ps
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLK_PER_BIT = 8,
    parameter int STUFF_RUN   = 6,
    parameter int LEN_W       = 5,
    parameter int ADDR_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              hs_req,
    input  logic              hs_nak,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dp_out,
    output logic              dm_out,
    output logic              out_en,
    output logic              pullup_en,
    output logic              busy
);
    localparam int BYTE_BITS = 8;
    localparam int BIT_W     = $clog2(BYTE_BITS);

    tx_state_e          state, state_nx;
    logic [7:0]         shreg, hold, hs_pid, src_byte;
    logic               hold_v, hs_mode, se0_half;
    logic [BIT_W-1:0]   bits_left;
    logic [LEN_W-1:0]   bytes_rem, fetch_rem;
    logic [ADDR_W-1:0]  addr_pend, addr_act;

    logic start_hs, start_tx, timer_run, slot_end, decide;
    logic do_stuff, use_sh, use_hold, finish, want, take, src_valid;
    logic line_j, stuff_due, nrzi_step, nrzi_bit;

    assign start_hs  = (state == ST_IDLE) && hs_req;
    assign start_tx  = (state == ST_IDLE) && !hs_req && tx_start && (tx_len != '0);
    assign timer_run = (state == ST_BITS) || (state == ST_SE0) || (state == ST_EOPJ);
    assign decide    = (state == ST_ARM) || ((state == ST_BITS) && slot_end);

    assign do_stuff  = (state == ST_BITS) && stuff_due;
    assign use_sh    = !do_stuff && (bits_left != '0);
    assign use_hold  = !do_stuff && (bits_left == '0) && (bytes_rem != '0) && hold_v;
    assign finish    = !do_stuff && !use_sh && !use_hold;
    assign nrzi_step = decide && !finish;
    assign nrzi_bit  = use_sh ? shreg[0] : hold[0];

    assign src_valid = hs_mode || tx_valid;
    assign src_byte  = hs_mode ? ((fetch_rem == LEN_W'(2)) ? SYNC_PATTERN : hs_pid) : tx_data;
    assign want      = ((state == ST_LOAD) || (state == ST_ARM) || (state == ST_BITS))
                       && !hold_v && (fetch_rem != '0);
    assign take      = want && src_valid;
    assign tx_ready  = want && !hs_mode;
    assign dev_addr  = addr_act;
    assign busy      = (state != ST_IDLE);

    usb_ls_slot_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .slot_end (slot_end)
    );

    usb_ls_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (start_hs || start_tx),
        .step       (nrzi_step),
        .bit_in     (nrzi_bit),
        .stuff_slot (do_stuff),
        .line_j     (line_j),
        .stuff_due  (stuff_due)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_hs || start_tx)           state_nx = ST_LOAD;
            ST_LOAD: if (hold_v)                         state_nx = ST_ARM;
            ST_ARM:                                      state_nx = ST_BITS;
            ST_BITS: if (decide && finish)               state_nx = ST_SE0;
            ST_SE0:  if (slot_end && se0_half)           state_nx = ST_EOPJ;
            ST_EOPJ: if (slot_end)                       state_nx = ST_REL;
            ST_REL:                                      state_nx = ST_IDLE;
            default:                                     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // byte path, counters and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            hold      <= '0;
            hold_v    <= 1'b0;
            hs_mode   <= 1'b0;
            hs_pid    <= PID_ACK;
            se0_half  <= 1'b0;
            bits_left <= '0;
            bytes_rem <= '0;
            fetch_rem <= '0;
            addr_pend <= '0;
            addr_act  <= '0;
        end else begin
            if (addr_wr) addr_pend <= addr_in;
            if (start_hs || start_tx) begin
                hs_mode   <= start_hs;
                hs_pid    <= hs_nak ? PID_NAK : PID_ACK;
                fetch_rem <= start_hs ? LEN_W'(2) : tx_len;
                bytes_rem <= start_hs ? LEN_W'(2) : tx_len;
                bits_left <= '0;
                hold_v    <= 1'b0;
                se0_half  <= 1'b0;
            end
            if (take) begin
                hold      <= src_byte;
                hold_v    <= 1'b1;
                fetch_rem <= fetch_rem - 1'b1;
            end
            if (decide && use_sh) begin
                shreg     <= {1'b0, shreg[7:1]};
                bits_left <= bits_left - 1'b1;
            end
            if (decide && use_hold) begin
                shreg     <= {1'b0, hold[7:1]};
                bits_left <= BIT_W'(BYTE_BITS - 1);
                hold_v    <= 1'b0;
                bytes_rem <= bytes_rem - 1'b1;
            end
            if ((state == ST_BITS) && decide && finish && !hs_mode) begin
                addr_act <= addr_pend;
            end
            if ((state == ST_SE0) && slot_end) begin
                se0_half <= ~se0_half;
            end
        end
    end

    // line outputs per state
    always_comb begin
        dp_out    = 1'b0;
        dm_out    = 1'b0;
        out_en    = 1'b0;
        pullup_en = 1'b0;
        unique case (state)
            ST_IDLE, ST_LOAD: ;
            ST_ARM, ST_REL: begin
                dm_out    = 1'b1;
                pullup_en = 1'b1;
            end
            ST_BITS: begin
                dp_out    = ~line_j;
                dm_out    = line_j;
                out_en    = 1'b1;
                pullup_en = 1'b1;
            end
            ST_SE0: begin
                out_en    = 1'b1;
                pullup_en = 1'b1;
            end
            ST_EOPJ: begin
                dm_out    = 1'b1;
                out_en    = 1'b1;
                pullup_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_ls_tx_chk.sv
`timescale 1ns/1ps
module usb_ls_tx_chk #(
    parameter int CLK_PER_BIT = 8,
    parameter int ADDR_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              busy,
    input logic              dp_out,
    input logic              dm_out,
    input logic              out_en,
    input logic              pullup_en,
    input logic [ADDR_W-1:0] dev_addr
);
    logic [15:0] drv_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !out_en) drv_cnt <= '0;
        else                   drv_cnt <= drv_cnt + 1'b1;
    end

    // R3
    slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && $past(out_en) && ({dp_out, dm_out} != $past({dp_out, dm_out})))
        |-> ((drv_cnt % 16'(CLK_PER_BIT)) == 16'd0));

    // R12
    no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_out && dm_out));

    // R2
    arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> (pullup_en && $past(pullup_en) && $past(dm_out) && !$past(dp_out)));

    // R7
    release_pullup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_en) |-> (pullup_en && dm_out && !dp_out));

    // R7
    release_pullup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_en) |=> !pullup_en);

    // R10
    addr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> (out_en && !dp_out && !dm_out));

    // R4
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_ready);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.CLK_PER_BIT(CLK_PER_BIT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .busy      (busy),
    .dp_out    (dp_out),
    .dm_out    (dm_out),
    .out_en    (out_en),
    .pullup_en (pullup_en),
    .dev_addr  (dev_addr)
);

// File: tb/usb_ls_tx_bench.sv
`timescale 1ns/1ps
module usb_ls_tx_bench;
    localparam int LEN_W  = 5;
    localparam int ADDR_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 1'b0, tx_valid = 1'b0, hs_req = 1'b0, hs_nak = 1'b0, addr_wr = 1'b0;
    logic [LEN_W-1:0]  tx_len = '0;
    logic [7:0]        tx_data = '0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] dev_addr;
    logic tx_ready, dp_out, dm_out, out_en, pullup_en, busy;

    always #2.5 clk = ~clk;

    usb_ls_tx u_usb_ls_tx (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .hs_req(hs_req), .hs_nak(hs_nak), .addr_wr(addr_wr), .addr_in(addr_in),
        .dev_addr(dev_addr), .dp_out(dp_out), .dm_out(dm_out), .out_en(out_en),
        .pullup_en(pullup_en), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    int pkts   = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pkt_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: decode the line, destuff, compare bytes against the scoreboard
    int         mon_cyc = 0, mon_ones = 0, mon_nbits = 0, mon_se0 = 0;
    bit         mon_jseen = 0, prev_oe = 0, rel_pending = 0, last_pu = 0;
    logic [1:0] mon_prev_line = 2'b01, last_lines = 2'b00, line;
    logic [7:0] mon_acc = '0;

    always @(negedge clk) begin
        line = {dp_out, dm_out};
        if (rst_n) begin
            if (out_en && !prev_oe) begin
                mon_cyc = 0; mon_ones = 0; mon_nbits = 0; mon_se0 = 0;
                mon_jseen = 0; mon_prev_line = 2'b01;
                chk(last_lines == 2'b01 && last_pu, "R2", "pre-drive idle", int'({last_pu, last_lines}), 5);
            end
            if (out_en) begin
                if (prev_oe && (mon_cyc % 8) != 0)
                    chk(line == last_lines, "R3", "mid-slot change", int'(line), int'(last_lines));
                if ((mon_cyc % 8) == 4) begin
                    if (line == 2'b00) begin
                        if (mon_se0 == 0) chk(mon_ones < 6, "R6", "stuff owed at EOP", mon_ones, 0);
                        mon_se0++;
                    end else if (mon_se0 != 0) begin
                        chk(!mon_jseen && line == 2'b01, "R7", "EOP J slot", int'(line), 1);
                        mon_jseen = 1;
                    end else begin
                        bit bitv;
                        bitv = (line == mon_prev_line);
                        mon_prev_line = line;
                        if (mon_ones == 6) begin
                            chk(!bitv, "R6", "stuff slot toggles", int'(bitv), 0);
                            mon_ones = 0;
                        end else begin
                            if (bitv) mon_ones++; else mon_ones = 0;
                            mon_acc = {bitv, mon_acc[7:1]};
                            mon_nbits++;
                            if (mon_nbits == 8) begin
                                mon_nbits = 0;
                                if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", int'(mon_acc), 0);
                                else begin
                                    logic [7:0] e;
                                    e = exp_q.pop_front();
                                    chk(mon_acc == e, "R5", "decoded byte", int'(mon_acc), int'(e));
                                end
                            end
                        end
                    end
                end
                mon_cyc++;
            end
            if (!out_en && prev_oe) begin
                chk(mon_cyc % 8 == 0, "R3", "driven length multiple of slot", mon_cyc, 0);
                chk(mon_se0 == 2, "R7", "SE0 slots", mon_se0, 2);
                chk(mon_jseen, "R7", "J after SE0", int'(mon_jseen), 1);
                chk(mon_nbits == 0, "R4", "byte aligned", mon_nbits, 0);
                chk(exp_q.size() == 0, "R4", "bytes left in scoreboard", exp_q.size(), 0);
                chk(pullup_en && line == 2'b01, "R7", "pull-up held after release", int'(pullup_en), 1);
                pkts++;
                rel_pending = 1;
            end else if (rel_pending) begin
                chk(!pullup_en, "R7", "pull-up dropped", int'(pullup_en), 0);
                rel_pending = 0;
            end
        end
        prev_oe    = out_en;
        last_lines = line;
        last_pu    = pullup_en;
    end

    task automatic send_data();
        foreach (pkt_q[i]) exp_q.push_back(pkt_q[i]);
        tx_start = 1'b1;
        tx_len   = LEN_W'(pkt_q.size());
        @(negedge clk);
        tx_start = 1'b0;
        foreach (pkt_q[i]) begin
            tx_data  = pkt_q[i];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
        end
        tx_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_hs(input bit nak);
        int lat;
        exp_q.push_back(8'h80);
        exp_q.push_back(nak ? 8'h5A : 8'hD2);
        hs_req = 1'b1;
        hs_nak = nak;
        @(negedge clk);
        hs_req = 1'b0;
        lat = 1;
        while (!out_en && lat < 200) begin @(negedge clk); lat++; end
        chk(lat >= 1 && lat <= 60, "R9", "reply latency", lat, 60);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk(!out_en && !pullup_en && !dp_out && !dm_out, "R1", "lines in reset",
            int'({out_en, pullup_en, dp_out, dm_out}), 0);
        chk(!busy && !tx_ready && dev_addr == '0, "R1", "busy/ready/addr in reset",
            int'({busy, tx_ready, dev_addr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        addr_in = 7'h2A; addr_wr = 1'b1; @(negedge clk); addr_wr = 1'b0;
        send_hs(1'b0);
        chk(dev_addr == 7'h00, "R10", "address after handshake", int'(dev_addr), 0);

        pkt_q = {}; pkt_q.push_back(8'h80); pkt_q.push_back(8'hC3); pkt_q.push_back(8'h55);
        send_data();
        chk(dev_addr == 7'h2A, "R10", "address after data packet", int'(dev_addr), 'h2A);

        pkt_q = {}; pkt_q.push_back(8'h80); pkt_q.push_back(8'hFF);
        pkt_q.push_back(8'hFF); pkt_q.push_back(8'h00);
        send_data();

        // R6: packet ending in six ones
        pkt_q = {}; pkt_q.push_back(8'h80); pkt_q.push_back(8'hFC);
        send_data();

        addr_in = 7'h15; addr_wr = 1'b1; @(negedge clk); addr_wr = 1'b0;
        send_hs(1'b1);
        chk(dev_addr == 7'h2A, "R10", "pending not committed by NAK", int'(dev_addr), 'h2A);

        pkt_q = {};
        for (int i = 0; i < 9; i++) pkt_q.push_back((i == 0) ? 8'h80 : 8'(i * 37 + 5));
        send_data();
        chk(dev_addr == 7'h15, "R10", "second commit", int'(dev_addr), 'h15);

        // R8: simultaneous requests, handshake wins
        begin
            int p0;
            p0 = pkts;
            exp_q.push_back(8'h80); exp_q.push_back(8'hD2);
            hs_req = 1'b1; hs_nak = 1'b0; tx_start = 1'b1; tx_len = 5'd3;
            @(negedge clk);
            hs_req = 1'b0; tx_start = 1'b0;
            chk(!tx_ready, "R8", "no stream fetch during handshake", int'(tx_ready), 0);
            while (busy) @(negedge clk);
            repeat (50) @(negedge clk);
            chk(pkts == p0 + 1 && !busy, "R8", "only handshake sent", pkts - p0, 1);
        end

        // R11: zero length ignored
        begin
            int p0;
            p0 = pkts;
            tx_start = 1'b1; tx_len = '0;
            @(negedge clk);
            tx_start = 1'b0;
            chk(!busy, "R11", "zero length start", int'(busy), 0);
            repeat (20) @(negedge clk);
            chk(pkts == p0, "R11", "no packet for zero length", pkts - p0, 0);
        end

        // R11: requests while busy ignored
        begin
            int p0;
            p0 = pkts;
            pkt_q = {}; pkt_q.push_back(8'h80); pkt_q.push_back(8'h12); pkt_q.push_back(8'h7E);
            fork
                send_data();
                begin
                    repeat (40) @(negedge clk);
                    hs_req = 1'b1;
                    @(negedge clk);
                    hs_req = 1'b0;
                end
            join
            repeat (60) @(negedge clk);
            chk(pkts == p0 + 1 && !busy, "R11", "request while busy", pkts - p0, 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule